// File: doc/BRIEF.md
# Byte-Lane SRAM Write Sequencer

This block turns a single host write request into a correctly ordered and timed write cycle on an external asynchronous SRAM with two byte lanes. The host raises a request together with an address, a data word, a two-bit lane mask, a cycle style and an output-enable flag. The block then drives the memory address, chip enable, semaphore select, read/write strobe, output enable, the two byte selects and a data bus with a driver enable. It answers with an acknowledge that stays high until the host drops its request.

There are two cycle styles. In the strobe style, chip enable falls first and the read/write strobe bounds the write. In the chip-enable style, the strobe falls first and chip enable bounds the write, so the memory never turns its outputs on. Every interval is a clock-cycle count taken from configuration inputs when a request is accepted: address setup, minimum write pulse, data setup, data hold, address hold, output turn-off and minimum cycle length.

The request also says whether output enable stays asserted during the write. In the strobe style with output enable asserted, the write pulse is lengthened. The data driver then waits for the memory's outputs to turn off before it starts driving.

Top module: `sram_wr_sequencer`

## Requirements
- R1: While reset is high and just after it, ack and mem_dq_oe are 0, and mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n and mem_lb_n are all 1.
- R2: The address is loaded onto mem_addr at the edge that accepts a request. It does not change while mem_rw_n is low. The write overlap (mem_ce_n, mem_rw_n and at least one byte select all low) begins after max(cfg_addr_setup,1) cycles.
- R3: req_be[1] selects the upper lane (mem_ub_n low) and req_be[0] selects the lower lane (mem_lb_n low) during the write. mem_sem_n is never low.
- R4: With req_mode=0 (strobe style) and req_oe_low=0, chip enable is already low and the strobe high in the cycle before the overlap. The overlap lasts max(cfg_pulse, cfg_data_setup, 1) cycles.
- R5: With req_mode=0 and req_oe_low=1, the overlap lasts max(cfg_pulse, cfg_oe_off+cfg_data_setup, 1) cycles. The data driver stays off for the first cfg_oe_off cycles of it.
- R6: With req_mode=1 (chip-enable style), the strobe is already low and chip enable high in the cycle before the overlap. The overlap lasts max(cfg_pulse, cfg_data_setup, 1) cycles, whatever req_oe_low is.
- R7: mem_dq_out carries req_data during the overlap. The driver is on for exactly the final (overlap length minus output wait) cycles of the overlap.
- R8: After the overlap ends, the driver stays on for exactly cfg_data_hold cycles. It is off when ack rises.
- R9: ack rises after max(S+P+max(cfg_data_hold, cfg_addr_hold, 1), cfg_cycle) busy cycles, where S is the setup length and P is the overlap length.
- R10: A request with req_be=00 is acknowledged one cycle after acceptance, and chip enable stays high.
- R11: ack stays high while req is high and drops one cycle after req falls.
- R12: The data driver is never on while output enable and chip enable are low and the memory may still be driving. That covers the strobe high, and fewer than cfg_oe_off cycles since the strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, held until ack |
| ack | output | 1 | Completion acknowledge, held until req falls |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data, upper lane in the high half |
| req_be | input | 2 | Lane mask: bit 1 upper, bit 0 lower |
| req_mode | input | 1 | 0 strobe style, 1 chip-enable style |
| req_oe_low | input | 1 | 1 keeps output enable asserted during the cycle |
| cfg_addr_setup | input | TW | Address setup cycles |
| cfg_pulse | input | TW | Minimum write pulse cycles |
| cfg_data_setup | input | TW | Data setup cycles |
| cfg_data_hold | input | TW | Data hold cycles |
| cfg_addr_hold | input | TW | Address hold cycles |
| cfg_oe_off | input | TW | Output turn-off cycles |
| cfg_cycle | input | TW | Minimum busy cycles per write |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_sem_n | output | 1 | Semaphore select, held high |
| mem_rw_n | output | 1 | Read/write strobe, low for write |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dq_out | output | DW | Write data to the bus |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with a 12-bit address, a 16-bit data word and 5-bit interval counts. At that width, every interval from zero up to 31 can be programmed. The cases run from all-zero timings, where every phase falls back to one cycle, through pulses set by the turn-off sum, by data setup and by the minimum pulse. They also include a cycle floor long enough to stretch the hold phase. Both cycle styles are run with output enable asserted and released, with each lane mask, and with an acknowledge held open for several cycles.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_ACK   = 3'd4
  } wr_state_t;

  localparam logic MODE_STROBE = 1'b0;
  localparam logic MODE_CHIPEN = 1'b1;
  localparam int   LANES       = 2;
endpackage

// File: rtl/sram_wr_span_counter.sv
module sram_wr_span_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (clr)      nxt = '0;
    else if (inc) nxt = q + W'(1);
    else          nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/sram_wr_pulse_calc.sv
module sram_wr_pulse_calc
  import sram_wr_pkg::*;
#(
  parameter int TW = 6,
  parameter int LW = TW + 2
) (
  input  logic          mode,
  input  logic          oe_low,
  input  logic [TW-1:0] t_as,
  input  logic [TW-1:0] t_wp,
  input  logic [TW-1:0] t_ds,
  input  logic [TW-1:0] t_dh,
  input  logic [TW-1:0] t_ah,
  input  logic [TW-1:0] t_hz,
  output logic [LW-1:0] setup_len,
  output logic [LW-1:0] pulse_len,
  output logic [LW-1:0] hz_wait,
  output logic [LW-1:0] hold_len
);
  localparam logic [LW-1:0] ONE = LW'(1);

  function automatic logic [LW-1:0] mx(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    hz_wait   = (mode == MODE_STROBE && oe_low) ? LW'(t_hz) : '0;
    setup_len = mx(LW'(t_as), ONE);
    pulse_len = mx(mx(LW'(t_wp), hz_wait + LW'(t_ds)), ONE);
    hold_len  = mx(mx(LW'(t_dh), LW'(t_ah)), ONE);
  end
endmodule

// File: rtl/sram_wr_lane_map.sv
module sram_wr_lane_map
  import sram_wr_pkg::*;
(
  input  logic             active,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] sel_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = !(active && be[g]);
  end
endmodule

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer
  import sram_wr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  output logic          ack,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_be,
  input  logic          req_mode,
  input  logic          req_oe_low,
  input  logic [TW-1:0] cfg_addr_setup,
  input  logic [TW-1:0] cfg_pulse,
  input  logic [TW-1:0] cfg_data_setup,
  input  logic [TW-1:0] cfg_data_hold,
  input  logic [TW-1:0] cfg_addr_hold,
  input  logic [TW-1:0] cfg_oe_off,
  input  logic [TW-1:0] cfg_cycle,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_sem_n,
  output logic          mem_rw_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  localparam int CW = TW + 2;

  wr_state_t st_q, st_n;
  logic          accept;
  logic          a_mode, a_oel;
  logic [1:0]    a_be;
  logic [TW-1:0] t_as, t_wp, t_ds, t_dh, t_ah, t_hz, t_wc;
  logic [CW-1:0] setup_len, pulse_len, hz_wait, hold_len;
  logic [CW-1:0] ph_q, ph_n, tot_q, tot_n;
  logic          ph_clr, busy_q, busy_n;
  logic          mode_eff, oel_eff;
  logic [1:0]    be_eff, sel_n;
  logic          seg_active;

  assign accept   = (st_q == ST_IDLE) && req;
  assign mode_eff = accept ? req_mode   : a_mode;
  assign oel_eff  = accept ? req_oe_low : a_oel;
  assign be_eff   = accept ? req_be     : a_be;
  assign busy_q   = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign busy_n   = (st_n == ST_SETUP) || (st_n == ST_PULSE) || (st_n == ST_HOLD);
  assign seg_active = (st_n == ST_SETUP) || (st_n == ST_PULSE);

  sram_wr_pulse_calc #(.TW(TW), .LW(CW)) u_calc (
    .mode      (a_mode),
    .oe_low    (a_oel),
    .t_as      (t_as),
    .t_wp      (t_wp),
    .t_ds      (t_ds),
    .t_dh      (t_dh),
    .t_ah      (t_ah),
    .t_hz      (t_hz),
    .setup_len (setup_len),
    .pulse_len (pulse_len),
    .hz_wait   (hz_wait),
    .hold_len  (hold_len)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:  if (req) st_n = (req_be == 2'b00) ? ST_ACK : ST_SETUP;
      ST_SETUP: if ((ph_q + CW'(1)) >= setup_len) st_n = ST_PULSE;
      ST_PULSE: if ((ph_q + CW'(1)) >= pulse_len) st_n = ST_HOLD;
      ST_HOLD:  if (((ph_q + CW'(1)) >= hold_len) &&
                    ((tot_q + CW'(1)) >= CW'(t_wc))) st_n = ST_ACK;
      ST_ACK:   if (!req) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign ph_clr = (st_n != st_q);

  sram_wr_span_counter #(.W(CW)) u_phase_cnt (
    .clk (clk), .rst (rst), .clr (ph_clr), .inc (1'b1), .q (ph_q), .nxt (ph_n)
  );

  sram_wr_span_counter #(.W(CW)) u_total_cnt (
    .clk (clk), .rst (rst), .clr (!busy_q), .inc (busy_q), .q (tot_q), .nxt (tot_n)
  );

  sram_wr_lane_map u_lanes (
    .active (seg_active),
    .be     (be_eff),
    .sel_n  (sel_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      a_mode <= MODE_STROBE;
      a_oel  <= 1'b0;
      a_be   <= 2'b00;
      t_as <= '0; t_wp <= '0; t_ds <= '0; t_dh <= '0;
      t_ah <= '0; t_hz <= '0; t_wc <= '0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        a_mode <= req_mode;
        a_oel  <= req_oe_low;
        a_be   <= req_be;
        t_as <= cfg_addr_setup;
        t_wp <= cfg_pulse;
        t_ds <= cfg_data_setup;
        t_dh <= cfg_data_hold;
        t_ah <= cfg_addr_hold;
        t_hz <= cfg_oe_off;
        t_wc <= cfg_cycle;
      end
    end
  end

  // Registered pin drivers, computed from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_sem_n  <= 1'b1;
      mem_rw_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      ack        <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_data;
      end
      mem_sem_n <= 1'b1;
      mem_ce_n  <= !(((st_n == ST_SETUP) && (mode_eff == MODE_STROBE)) || (st_n == ST_PULSE));
      mem_rw_n  <= !(((st_n == ST_SETUP) && (mode_eff == MODE_CHIPEN)) || (st_n == ST_PULSE));
      mem_oe_n  <= !(busy_n && oel_eff);
      mem_ub_n  <= sel_n[1];
      mem_lb_n  <= sel_n[0];
      mem_dq_oe <= ((st_n == ST_PULSE) && (ph_n >= hz_wait)) ||
                   ((st_n == ST_HOLD) && (ph_n < CW'(t_dh)));
      ack       <= (st_n == ST_ACK);
    end
  end

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_rw_n && !$past(mem_rw_n)) |-> (mem_addr == $past(mem_addr)));

  // R3
  sem_high_chk: assert property (@(posedge clk) disable iff (rst) mem_sem_n);

  // R6
  ce_after_rw_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_ce_n) && (a_mode == MODE_CHIPEN)) |-> !mem_rw_n);

  // R8
  ack_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> !mem_dq_oe);

  // R10
  ce_needs_lane_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (!mem_ub_n || !mem_lb_n));

  // R11
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);
endmodule

// File: tb/sram_wr_sequencer_tb.sv
`timescale 1ns/1ps
module sram_wr_sequencer_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int TW = 5;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    be;
    logic          mode;
    logic [7:0]    s, p, dsu, dh, b;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ack;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0]    req_be = '0;
  logic          req_mode = 1'b0, req_oe_low = 1'b0;
  logic [TW-1:0] c_as = '0, c_wp = '0, c_ds = '0, c_dh = '0, c_ah = '0, c_hz = '0, c_wc = '0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  sram_wr_sequencer #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .req(req), .ack(ack),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .req_mode(req_mode), .req_oe_low(req_oe_low),
    .cfg_addr_setup(c_as), .cfg_pulse(c_wp), .cfg_data_setup(c_ds),
    .cfg_data_hold(c_dh), .cfg_addr_hold(c_ah), .cfg_oe_off(c_hz), .cfg_cycle(c_wc),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_sem_n(mem_sem_n),
    .mem_rw_n(mem_rw_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Monitor state
  int  busy_cyc = 0, pre = 0, ov_len = 0, dsu = 0, dh = 0, kcnt = 0;
  bit  ov_seen = 0, ce_seen = 0, prev_ack = 0, pc_ce = 1, pc_rw = 1;
  bit  drv = 0, contention = 0, addr_moved = 0, sem_low = 0;
  int  order = 0;
  logic [AW-1:0] cap_addr, prev_addr;
  logic [DW-1:0] cap_data;
  logic [1:0]    cap_sel;
  int  cur_hz = 0;

  always @(negedge clk) begin
    if (!rst) begin
      bit ov;
      ov = !mem_ce_n && !mem_rw_n && (!mem_ub_n || !mem_lb_n);
      if (!mem_sem_n) sem_low = 1;
      // R12 contention monitor
      if (!mem_ce_n && !mem_oe_n && mem_rw_n) begin drv = 1; kcnt = 0; end
      if (mem_dq_oe && !mem_oe_n && !mem_ce_n &&
          (mem_rw_n || (drv && kcnt < cur_hz))) contention = 1;
      if (drv && !mem_rw_n) kcnt++;
      if (mem_ce_n) drv = 0;
      // R2 address monitor
      if (!mem_rw_n && !pc_rw && mem_addr != prev_addr) addr_moved = 1;
      if (req && !ack) begin
        busy_cyc++;
        if (!mem_ce_n) ce_seen = 1;
        if (ov) begin
          if (!ov_seen) begin
            if (!pc_ce && pc_rw) order = 1;
            else if (pc_ce && !pc_rw) order = 2;
            else order = 3;
          end
          ov_seen = 1;
          ov_len++;
          if (mem_dq_oe) dsu++;
          cap_addr = mem_addr;
          cap_data = mem_dq_out;
          cap_sel  = {mem_ub_n, mem_lb_n};
        end else if (ov_seen) begin
          if (mem_dq_oe) dh++;
        end else pre++;
      end
      if (ack && !prev_ack) begin
        exp_t e;
        if (q.size() == 0) chk("R9 unexpected ack", 1, 0);
        else begin
          e = q.pop_front();
          chk("R9 busy cycles", busy_cyc, e.b);
          chk("R8 driver off at ack", mem_dq_oe, 0);
          chk("R12 contention", contention, 0);
          chk("R3 semaphore high", sem_low, 0);
          if (e.be == 2'b00) begin
            chk("R10 chip enable untouched", ce_seen, 0);
          end else begin
            chk("R2 address", cap_addr, e.addr);
            chk("R2 address stable", addr_moved, 0);
            chk("R2 setup cycles", pre, e.s);
            chk("R3 lane selects", cap_sel, {~e.be[1], ~e.be[0]});
            chk(e.mode ? "R6 overlap length" : "R4 R5 overlap length", ov_len, e.p);
            chk(e.mode ? "R6 strobe before ce" : "R4 ce before strobe", order, e.mode ? 2 : 1);
            chk("R7 data value", cap_data, e.data);
            chk("R7 R5 driven cycles in overlap", dsu, e.dsu);
            chk("R8 hold cycles", dh, e.dh);
          end
        end
        busy_cyc = 0; pre = 0; ov_len = 0; dsu = 0; dh = 0; ov_seen = 0;
        ce_seen = 0; order = 0; contention = 0; addr_moved = 0; sem_low = 0;
      end
      prev_ack  = ack;
      pc_ce     = mem_ce_n;
      pc_rw     = mem_rw_n;
      prev_addr = mem_addr;
    end
  end

  task automatic run(input bit mode, input bit oel, input logic [1:0] be,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int tas, input int twp, input int tds, input int tdh,
                     input int tah, input int thz, input int twc, input bit hold_open);
    exp_t e;
    int hzw;
    @(negedge clk); #1;
    hzw = (!mode && oel) ? thz : 0;
    e.addr = a; e.data = d; e.be = be; e.mode = mode;
    e.s   = 8'(mx(tas, 1));
    e.p   = 8'(mx(mx(twp, hzw + tds), 1));
    e.dsu = 8'(int'(e.p) - hzw);
    e.dh  = 8'(tdh);
    e.b   = (be == 2'b00) ? 8'd0 : 8'(mx(int'(e.s) + int'(e.p) + mx(mx(tdh, tah), 1), twc));
    q.push_back(e);
    cur_hz = thz;
    c_as = TW'(tas); c_wp = TW'(twp); c_ds = TW'(tds); c_dh = TW'(tdh);
    c_ah = TW'(tah); c_hz = TW'(thz); c_wc = TW'(twc);
    req_mode = mode; req_oe_low = oel; req_be = be; req_addr = a; req_data = d;
    req = 1'b1;
    do @(negedge clk); while (!ack);
    if (hold_open) begin
      repeat (3) @(negedge clk);
      chk("R11 ack held with req", ack, 1);
    end
    #1 req = 1'b0;
    @(negedge clk);
    chk("R11 ack drops after req", ack, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 outputs during reset
    chk("R1 reset ack/oe", {ack, mem_dq_oe}, 0);
    chk("R1 reset strobes", {mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n, mem_lb_n}, 6'b111111);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 idle strobes", {mem_ce_n, mem_sem_n, mem_rw_n, mem_oe_n, mem_ub_n, mem_lb_n}, 6'b111111);
    // R4 strobe style, OE released
    run(0, 0, 2'b11, 12'h123, 16'hA55A, 2, 3, 2, 1, 2, 2, 4, 0);
    // R5 strobe style, OE asserted: pulse set by turn-off + setup
    run(0, 1, 2'b10, 12'h0F0, 16'h1234, 1, 3, 2, 2, 1, 2, 0, 0);
    // R6 chip-enable style, OE asserted
    run(1, 1, 2'b01, 12'hABC, 16'hBEEF, 3, 3, 2, 1, 1, 4, 0, 0);
    // R9 cycle stretch
    run(0, 0, 2'b01, 12'h777, 16'h0F0F, 1, 2, 1, 1, 1, 0, 20, 0);
    // R10 empty mask
    run(0, 1, 2'b00, 12'h555, 16'hFFFF, 3, 3, 3, 3, 3, 3, 9, 0);
    // all-zero timings
    run(1, 0, 2'b11, 12'h001, 16'h8001, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 data setup dominates, R11 open ack
    run(1, 0, 2'b10, 12'hFFE, 16'h7E7E, 2, 1, 4, 3, 5, 0, 0, 1);
    // R5 long turn-off
    run(0, 1, 2'b11, 12'h3C3, 16'hC3C3, 2, 2, 1, 0, 4, 5, 0, 0);
    // R7 pulse set by minimum width
    run(0, 0, 2'b10, 12'h246, 16'h9182, 1, 6, 2, 2, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    chk("R9 no pending items", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule